// File: doc/BRIEF.md
# Multi-drop parallel position bus slave

This block is one station on a shared parallel bus that up to seven identical stations use. A bus master places a 5-bit address on the bus and pulls a shared active-low enable. The upper three address bits pick a station by its configured base address. The lower two bits pick a register inside that station. A selected station can return a frozen snapshot of a 36-bit two's complement position, a snapshot of a status word, or a fixed test word used to find open or bridged data lines. A selected station can also be told to clear its errors.

Base address 0 is the broadcast group. Every station acts on it at the same moment. One code freezes position and status in all stations together, so that the master can then read them one after another. Another code clears errors everywhere. The remaining codes are reserved. Each station keeps an active-low error output that holds after any fault. A clear request releases it only when no fault input is still active.

All bus inputs are sampled on the block clock. The output side is a data word plus an output-enable, which feeds the pad-level tri-state driver.

Top module: `posbus_slave`

## Requirements
- R1: After reset, `data_oe` is 0, `data_out` is 0, `err_n` is 1, and both snapshots are zero.
- R2: A fall of `bus_en_n` is the first clock edge that samples it low after it was sampled high. When such a fall is accepted with address `{unit_base, 2'b00}`, the station returns the position snapshot, with bit 0 as the LSB and bit 35 as the MSB. `data_oe` rises as a result of the second clock edge that samples enable low, not the first.
- R3: Address `{unit_base, 2'b01}` returns the status snapshot. Bits [15:0] hold `status_in`, bits [19:16] hold the sticky error flags, and the upper bits are zero.
- R4: Address `{unit_base, 2'b11}` returns the constant 36'hA5A5A5A5A.
- R5: An address whose upper three bits differ from `unit_base` never causes this station to drive.
- R6: When `unit_base` is 0, the station never asserts `data_oe`. It still obeys broadcast codes.
- R7: The first clock edge that samples `bus_en_n` high drops `data_oe` and returns `data_out` to 0.
- R8: Address 5'b00000 (latch all) copies `pos_in` and the status word at the fall edge in every station. Neither snapshot changes until the next latch-all.
- R9: Any `fault_in` bit that is high at a clock edge sets its sticky flag. `err_n` is low from that edge on.
- R10: A reset request clears all flags and releases `err_n`, but only if `fault_in` is all zero at the fall edge. Otherwise the request does nothing. A reset request is address `{unit_base, 2'b10}` with a nonzero base, or 5'b00010 for all stations.
- R11: The reserved broadcast codes 5'b00001 and 5'b00011 change neither the snapshots nor the error state, and cause no drive.
- R12: A fall is ignored if enable was sampled high on fewer than 2 consecutive edges just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Station number (upper 3 bits) and register code (lower 2 bits) |
| bus_en_n | input | 1 | Shared active-low bus enable |
| unit_base | input | 3 | Configured station number; 0 means never drive |
| pos_in | input | 36 | Live two's complement position |
| status_in | input | 16 | Live status bits |
| fault_in | input | 4 | Level fault conditions |
| data_out | output | 36 | Word for the bus driver; zero when not driving |
| data_oe | output | 1 | Enable for the bus driver |
| err_n | output | 1 | Active-low sticky error |

## Verification
The bench reads the position snapshot after the live input has changed. A design that reads live values instead of the frozen copy returns the new value. It issues a clear while a fault is still active, and a design that clears unconditionally would let `err_n` rise. It sends every reserved broadcast code, and drives from a station configured as base 0. Either mistake shows up as an unexpected `data_oe` or as a changed snapshot. It also gives an enable-high gap of a single cycle, so a design without the gap rule answers an access it must ignore. Finally, it samples the cycle before the data should appear, which catches a design that drives one cycle early.

// File: rtl/posbus_pkg.sv
package posbus_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RD_POS,
        CMD_RD_STAT,
        CMD_RD_TEST,
        CMD_RESET,
        CMD_LATCH_ALL
    } cmd_e;

    // Nibbles alternate A,5 starting from the LSB nibble.
    function automatic logic [63:0] test_word();
        logic [63:0] w;
        logic [3:0]  nib;
        w = '0;
        for (int i = 0; i < 64; i++) begin
            nib  = ((i / 4) % 2 == 0) ? 4'hA : 4'h5;
            w[i] = nib[i % 4];
        end
        return w;
    endfunction

endpackage

// File: rtl/posbus_decode.sv
module posbus_decode
    import posbus_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BASE_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    output cmd_e              cmd
);
    localparam int REG_W = ADDR_W - BASE_W;

    logic [BASE_W-1:0] addr_base;
    logic [REG_W-1:0]  code;

    assign addr_base = addr[ADDR_W-1 -: BASE_W];
    assign code      = addr[REG_W-1:0];

    always_comb begin
        cmd = CMD_NONE;
        if (addr_base == '0) begin
            if (code == REG_W'(0))      cmd = CMD_LATCH_ALL;
            else if (code == REG_W'(2)) cmd = CMD_RESET;
        end else if ((base != '0) && (addr_base == base)) begin
            if (code == REG_W'(0))      cmd = CMD_RD_POS;
            else if (code == REG_W'(1)) cmd = CMD_RD_STAT;
            else if (code == REG_W'(2)) cmd = CMD_RESET;
            else if (code == REG_W'(3)) cmd = CMD_RD_TEST;
        end
    end

endmodule

// File: rtl/posbus_gap.sv
module posbus_gap #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic accept
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] hi;
    } gap_t;

    gap_t gap_d, gap_q;

    always_comb begin
        gap_d    = gap_q;
        gap_d.en = en_n;
        if (!en_n)
            gap_d.hi = '0;
        else if (gap_q.hi != CNT_W'(MIN_HIGH))
            gap_d.hi = gap_q.hi + 1'b1;
    end

    assign accept = gap_q.en && !en_n && (gap_q.hi == CNT_W'(MIN_HIGH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q.en <= 1'b1;
            gap_q.hi <= CNT_W'(MIN_HIGH);
        end else begin
            gap_q <= gap_d;
        end
    end

endmodule

// File: rtl/posbus_err.sv
module posbus_err #(
    parameter int FAULT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAULT_W-1:0] fault_in,
    input  logic               clear_req,
    output logic [FAULT_W-1:0] flags,
    output logic               err_n
);
    logic [FAULT_W-1:0] flags_d, flags_q;

    always_comb begin
        if (clear_req && (fault_in == '0))
            flags_d = '0;
        else
            flags_d = flags_q | fault_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign err_n = ~(|flags_q);

endmodule

// File: rtl/posbus_slave.sv
module posbus_slave
    import posbus_pkg::*;
#(
    parameter int POS_W    = 36,
    parameter int ADDR_W   = 5,
    parameter int BASE_W   = 3,
    parameter int STAT_W   = 16,
    parameter int FAULT_W  = 4,
    parameter int MIN_HIGH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_en_n,
    input  logic [BASE_W-1:0]  unit_base,
    input  logic [POS_W-1:0]   pos_in,
    input  logic [STAT_W-1:0]  status_in,
    input  logic [FAULT_W-1:0] fault_in,
    output logic [POS_W-1:0]   data_out,
    output logic               data_oe,
    output logic               err_n
);
    localparam logic [POS_W-1:0] TEST_PAT = POS_W'(test_word());

    typedef struct packed {
        logic [POS_W-1:0] pos_lat;
        logic [POS_W-1:0] stat_lat;
        cmd_e             pend;
        logic             oe;
        logic [POS_W-1:0] data;
    } slv_t;

    slv_t st_d, st_q;

    cmd_e               cmd;
    logic               accept;
    logic               clear_req;
    logic [FAULT_W-1:0] flags;
    logic [POS_W-1:0]   stat_word;

    posbus_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) dec_i (
        .addr (bus_addr),
        .base (unit_base),
        .cmd  (cmd)
    );

    posbus_gap #(.MIN_HIGH(MIN_HIGH)) gap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (bus_en_n),
        .accept (accept)
    );

    assign clear_req = accept && (cmd == CMD_RESET);

    posbus_err #(.FAULT_W(FAULT_W)) err_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_in  (fault_in),
        .clear_req (clear_req),
        .flags     (flags),
        .err_n     (err_n)
    );

    always_comb begin
        stat_word = '0;
        stat_word[STAT_W-1:0]       = status_in;
        stat_word[STAT_W +: FAULT_W] = flags;
    end

    always_comb begin
        st_d = st_q;
        if (bus_en_n) begin
            st_d.oe   = 1'b0;
            st_d.data = '0;
            st_d.pend = CMD_NONE;
        end else if (st_q.pend != CMD_NONE) begin
            st_d.oe   = 1'b1;
            st_d.pend = CMD_NONE;
            case (st_q.pend)
                CMD_RD_POS:  st_d.data = st_q.pos_lat;
                CMD_RD_STAT: st_d.data = st_q.stat_lat;
                default:     st_d.data = TEST_PAT;
            endcase
        end
        if (accept) begin
            case (cmd)
                CMD_LATCH_ALL: begin
                    st_d.pos_lat  = pos_in;
                    st_d.stat_lat = stat_word;
                end
                CMD_RD_POS, CMD_RD_STAT, CMD_RD_TEST: st_d.pend = cmd;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos_lat  <= '0;
            st_q.stat_lat <= '0;
            st_q.pend     <= CMD_NONE;
            st_q.oe       <= 1'b0;
            st_q.data     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.data;
    assign data_oe  = st_q.oe;

endmodule

// File: rtl/posbus_slave_chk.sv
module posbus_slave_chk #(
    parameter int POS_W   = 36,
    parameter int ADDR_W  = 5,
    parameter int BASE_W  = 3,
    parameter int FAULT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_en_n,
    input logic [BASE_W-1:0]  unit_base,
    input logic [FAULT_W-1:0] fault_in,
    input logic [POS_W-1:0]   data_out,
    input logic               data_oe,
    input logic               err_n
);
    // R7
    release_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_n |=> !data_oe);

    // R2
    drive_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> (!$past(bus_en_n) && !$past(bus_en_n, 2)));

    // R6
    base_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(unit_base) == '0) |-> !data_oe);

    // R9
    fault_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> !err_n);

    // R10
    clear_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_n && $past(!err_n)) |-> ($past(fault_in) == '0));

    // R7
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_oe && $past(bus_en_n)) |-> (data_out == '0));

    logic unused_addr;
    assign unused_addr = ^bus_addr;

endmodule

bind posbus_slave posbus_slave_chk #(
    .POS_W(POS_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .FAULT_W(FAULT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
    .unit_base(unit_base), .fault_in(fault_in), .data_out(data_out),
    .data_oe(data_oe), .err_n(err_n)
);

// File: tb/posbus_slave_tb.sv
module posbus_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = 5'b11111;
    logic        bus_en_n = 1'b1;
    logic [2:0]  unit_base = 3'd2;
    logic [35:0] pos_in = '0;
    logic [15:0] status_in = '0;
    logic [3:0]  fault_in = '0;
    logic [35:0] data_out;
    logic        data_oe;
    logic        err_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    posbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
        .unit_base(unit_base), .pos_in(pos_in), .status_in(status_in),
        .fault_in(fault_in), .data_out(data_out), .data_oe(data_oe),
        .err_n(err_n)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [35:0] pos;
        logic [15:0] stat;
        logic        exp_oe;
        logic [35:0] exp_data;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{5'b00000, 36'h123456789, 16'h00C3, 1'b0, 36'h0},           // R8 latch
        '{5'b01000, 36'h000000000, 16'h0000, 1'b1, 36'h123456789},   // R2
        '{5'b01001, 36'h000000000, 16'hFFFF, 1'b1, 36'h0000000C3},   // R3
        '{5'b01011, 36'h000000000, 16'h0000, 1'b1, 36'hA5A5A5A5A},   // R4
        '{5'b01100, 36'h000000000, 16'h0000, 1'b0, 36'h0},           // R5
        '{5'b00000, 36'hFFFFFFFFE, 16'h1234, 1'b0, 36'h0},           // R8
        '{5'b01000, 36'h000000000, 16'h0000, 1'b1, 36'hFFFFFFFFE},   // R2 negative
        '{5'b00001, 36'h000000007, 16'h0000, 1'b0, 36'h0},           // R11
        '{5'b01000, 36'h000000000, 16'h0000, 1'b1, 36'hFFFFFFFFE},   // R11
        '{5'b00011, 36'h000000005, 16'h5555, 1'b0, 36'h0},           // R11
        '{5'b01001, 36'h000000000, 16'h0000, 1'b1, 36'h000001234}    // R11
    };

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [4:0] a, output logic oe_early,
                          output logic oe_s, output logic [35:0] d_s);
        @(negedge clk);
        bus_addr = a;
        bus_en_n = 1'b0;
        @(negedge clk);
        oe_early = data_oe;
        @(negedge clk);
        oe_s = data_oe;
        d_s  = data_out;
        @(negedge clk);
        bus_en_n = 1'b1;
        @(negedge clk);
        check("R7 oe after rise", {35'b0, data_oe}, 36'h0);
        check("R7 data after rise", data_out, 36'h0);
    endtask

    task automatic expect_access(input string tag, input logic [4:0] a,
                                 input logic exp_oe, input logic [35:0] exp_d);
        logic e, o;
        logic [35:0] d;
        access(a, e, o, d);
        check({tag, " early oe"}, {35'b0, e}, 36'h0);
        check({tag, " oe"}, {35'b0, o}, {35'b0, exp_oe});
        check({tag, " data"}, d, exp_d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic e, o;
        logic [35:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe", {35'b0, data_oe}, 36'h0);
        check("R1 data", data_out, 36'h0);
        check("R1 err_n", {35'b0, err_n}, 36'h1);
        rst_n = 1'b1;
        @(negedge clk);
        expect_access("R1 pos snapshot", 5'b01000, 1'b1, 36'h0);

        for (int i = 0; i < 11; i++) begin
            pos_in    = VECS[i].pos;
            status_in = VECS[i].stat;
            expect_access($sformatf("vec%0d R2/R3/R4/R5/R8/R11", i),
                          VECS[i].addr, VECS[i].exp_oe, VECS[i].exp_data);
        end

        // R9 sticky error from a one-cycle pulse
        @(negedge clk) fault_in = 4'b0001;
        @(negedge clk) fault_in = 4'b0000;
        repeat (3) @(negedge clk);
        check("R9 err_n held", {35'b0, err_n}, 36'h0);

        // R3 flags in status bits 19:16
        status_in = 16'h00C3;
        expect_access("R8 latch", 5'b00000, 1'b0, 36'h0);
        expect_access("R3 flags", 5'b01001, 1'b1, 36'h0000100C3);

        // R10 reset refused while fault active
        fault_in = 4'b0010;
        expect_access("R10 own reset busy", 5'b01010, 1'b0, 36'h0);
        check("R10 err_n stays", {35'b0, err_n}, 36'h0);
        fault_in = 4'b0000;
        // R11 reserved codes do not clear
        expect_access("R11 reserved 1", 5'b00001, 1'b0, 36'h0);
        expect_access("R11 reserved 3", 5'b00011, 1'b0, 36'h0);
        check("R11 err_n stays", {35'b0, err_n}, 36'h0);
        // R10 own reset succeeds
        expect_access("R10 own reset", 5'b01010, 1'b0, 36'h0);
        check("R10 err_n released", {35'b0, err_n}, 36'h1);
        // R10 broadcast reset
        @(negedge clk) fault_in = 4'b1000;
        @(negedge clk) fault_in = 4'b0000;
        @(negedge clk);
        check("R9 err_n second", {35'b0, err_n}, 36'h0);
        expect_access("R10 reset all", 5'b00010, 1'b0, 36'h0);
        check("R10 err_n after reset all", {35'b0, err_n}, 36'h1);
        expect_access("R8 latch", 5'b00000, 1'b0, 36'h0);
        expect_access("R10 flags gone", 5'b01001, 1'b1, 36'h0000000C3);

        // R6 base 0 never drives but obeys broadcast
        unit_base = 3'd0;
        pos_in    = 36'h000000ABC;
        expect_access("R6 latch", 5'b00000, 1'b0, 36'h0);
        pos_in    = 36'h0;
        expect_access("R6 code1", 5'b00001, 1'b0, 36'h0);
        expect_access("R6 code3", 5'b00011, 1'b0, 36'h0);
        expect_access("R6 other base", 5'b01000, 1'b0, 36'h0);
        unit_base = 3'd2;
        expect_access("R6 latched in base0", 5'b01000, 1'b1, 36'h000000ABC);

        // R12 short enable-high gap is ignored
        @(negedge clk);
        bus_addr = 5'b01000;
        bus_en_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 first access", {35'b0, data_oe}, 36'h1);
        bus_en_n = 1'b1;
        @(negedge clk);
        bus_addr = 5'b01011;
        bus_en_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 short gap oe", {35'b0, data_oe}, 36'h0);
        check("R12 short gap data", data_out, 36'h0);
        bus_en_n = 1'b1;
        @(negedge clk);
        access(5'b01011, e, o, d);
        check("R12 recovered oe", {35'b0, o}, 36'h1);
        check("R4 recovered data", d, 36'hA5A5A5A5A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule